// File: doc/BRIEF.md
# Speculative Narrow/Wide Fixed-Point Multiply-Accumulate Unit

This block multiplies a stream of signed fixed-point operand pairs and sums the products for convolution kernels. Operands and the result use a 24-bit two's complement word with 8 fraction bits (16.8). Each product is truncated, not rounded, back to that scale. Most values in such workloads are small, so every operation first runs on a cheaper 16-bit datapath with 8 integer and 8 fraction bits. The unit moves to the full 24-bit datapath only when the narrow attempt would lose information.

When a narrow attempt fails, the operand pair is not consumed. The unit raises `busy` for exactly one cycle. The source holds the same pair, and the unit executes it again on the wide datapath from the untouched accumulator. The result is therefore identical to a computation done wide from the start. The unit stays wide until the next start strobe. Wide sums that leave the 24-bit range clamp to the nearest extreme and set a sticky flag.

Top module: `spec_mac`

## Requirements
- R1: After reset, `accOut` is 0 and `resValid`, `wideMode`, `satFlag` and `busy` are all 0.
- R2: An accepted pair (`inValid`=1, `busy`=0) adds floor(a*b / 256) to the accumulator, where a and b are the signed 24-bit operand values scaled by 256. Dropped low bits are never rounded, and `accOut` matches a pure 24-bit reference after every operation.
- R3: A pair presented with `inStart`=1 starts a new accumulation from zero. It clears `satFlag` and returns the unit to narrow mode before that pair is evaluated.
- R4: In narrow mode the pair is refused (`busy`=1 in that cycle, accumulator unchanged) when either operand lies outside [-32768, 32767], when the truncated product lies outside that range, or when the new sum lies outside that range.
- R5: In the cycle after a refusal, `wideMode` is 1 and the held pair is executed on the 24-bit datapath without a refusal.
- R6: Once `wideMode` is 1, it stays 1 until a pair with `inStart`=1 is presented.
- R7: In wide mode, a sum above 8388607 or below -8388608 is clamped to that bound and sets `satFlag`. `satFlag` stays set until the next start.
- R8: `resValid` is 1 for exactly the one cycle after an accepted pair marked `inLast`, and `accOut` holds the final sum in that cycle.
- R9: While `inValid` is 0, `opA`, `opB`, `inStart` and `inLast` have no effect on any output.
- R10: `busy` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair present |
| inStart | input | 1 | This pair begins a new accumulation |
| inLast | input | 1 | This pair ends the accumulation |
| opA | input | 24 | Signed 16.8 operand |
| opB | input | 24 | Signed 16.8 operand |
| accOut | output | 24 | Accumulator, signed 16.8 |
| resValid | output | 1 | Final result present |
| wideMode | output | 1 | 24-bit datapath in use |
| satFlag | output | 1 | Sticky wide-mode clamp indicator |
| busy | output | 1 | Pair refused this cycle; hold it |

## Verification
The assertions assume that the source keeps `opA`, `opB`, `inStart` and `inLast` unchanged while `busy` is high. They also assume that start and last are only meaningful together with `inValid`. The stimulus tasks hold every field of a refused pair for the retry cycle. While the bench is idle it drives `inValid` low and leaves the other inputs at arbitrary values. Operand values stay within the signed 24-bit range, so the reference model works on exact integers.

// File: rtl/spec_mac_pkg.sv
package spec_mac_pkg;
  // strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic load;      // commit the computed sum
    logic wide;      // evaluate on the 24-bit path
    logic zeroBase;  // accumulate from zero (start of a new run)
    logic stall;     // narrow attempt refused, retry next cycle
  } macCtl_t;
endpackage

// File: rtl/spec_mac_ctrl.sv
module spec_mac_ctrl
  import spec_mac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inStart,
  input  logic    inLast,
  input  logic    narrowOvf,
  output macCtl_t ctl,
  output logic    wideMode,
  output logic    resValid,
  output logic    busy
);
  logic retryQ, wideQ, validQ;
  logic wideEff, zeroBase, stall, load;

  always_comb begin
    wideEff  = retryQ | (wideQ & ~inStart);
    zeroBase = inStart & ~retryQ;
    stall    = inValid & ~wideEff & narrowOvf;
    load     = inValid & ~stall;
  end

  assign ctl      = '{load: load, wide: wideEff, zeroBase: zeroBase, stall: stall};
  assign wideMode = wideQ;
  assign resValid = validQ;
  assign busy     = stall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryQ <= 1'b0;
      wideQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      retryQ <= stall;
      validQ <= load & inLast;
      if (stall)     wideQ <= 1'b1;
      else if (load) wideQ <= wideEff;
    end
  end

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);                                              // R10
  AST_REFUSE_WIDENS: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> wideMode);                                           // R5
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !busy && inLast) |=> resValid);                   // R8
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && !(inValid && inStart)) |=> wideMode);            // R6
endmodule

// File: rtl/spec_mac_dp.sv
module spec_mac_dp
  import spec_mac_pkg::*;
#(
  parameter int FRAC = 8,
  parameter int NINT = 8,
  parameter int WINT = 16
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WINT+FRAC-1:0]      opA,
  input  logic [WINT+FRAC-1:0]      opB,
  input  macCtl_t                   ctl,
  output logic                      narrowOvf,
  output logic [WINT+FRAC-1:0]      accOut,
  output logic                      satFlag
);
  localparam int W  = WINT + FRAC;
  localparam int N  = NINT + FRAC;
  localparam int PW = 2 * W;
  localparam int PN = 2 * N;
  localparam logic signed [PW:0] MAXV = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW:0] MINV = {{(W+2){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] accQ, base, nextVal;
  logic                satQ, satHit;

  // narrow path
  logic signed [N-1:0]  aN, bN;
  logic signed [PN-1:0] prodN;
  logic [N:0]           sumN;
  logic                 fitA, fitB, fitP, sumOvf;

  // wide path
  logic signed [PW-1:0] prodW;
  logic signed [PW:0]   sumW;
  logic signed [W-1:0]  wideVal;

  always_comb begin
    base  = ctl.zeroBase ? '0 : accQ;
    aN    = opA[N-1:0];
    bN    = opB[N-1:0];
    fitA  = (&opA[W-1:N-1]) | ~(|opA[W-1:N-1]);
    fitB  = (&opB[W-1:N-1]) | ~(|opB[W-1:N-1]);
    prodN = PN'(aN) * PN'(bN);
    fitP  = (&prodN[PN-1:N+FRAC-1]) | ~(|prodN[PN-1:N+FRAC-1]);
    sumN  = {base[N-1], base[N-1:0]} +
            {prodN[N+FRAC-1], prodN[N+FRAC-1:FRAC]};
    sumOvf    = sumN[N] ^ sumN[N-1];
    narrowOvf = ~fitA | ~fitB | ~fitP | sumOvf;

    prodW = PW'($signed(opA)) * PW'($signed(opB));
    sumW  = (PW+1)'(base) + (PW+1)'(prodW >>> FRAC);
    if (sumW > MAXV) begin
      wideVal = MAXW;
      satHit  = 1'b1;
    end else if (sumW < MINV) begin
      wideVal = MINW;
      satHit  = 1'b1;
    end else begin
      wideVal = sumW[W-1:0];
      satHit  = 1'b0;
    end

    nextVal = ctl.wide ? wideVal : {{(W-N){sumN[N-1]}}, sumN[N-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      satQ <= 1'b0;
    end else if (ctl.load) begin
      accQ <= nextVal;
      satQ <= (satQ & ~ctl.zeroBase) | (ctl.wide & satHit);
    end else if (ctl.stall && ctl.zeroBase) begin
      accQ <= '0;
      satQ <= 1'b0;
    end
  end

  assign accOut  = accQ;
  assign satFlag = satQ;

  AST_NARROW_FITS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.wide) |=>
      ((&accQ[W-1:N-1]) || !(|accQ[W-1:N-1])));                   // R4
  AST_SAT_EXTREME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satQ) |-> (accQ == MAXW || accQ == MINW));              // R7
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satQ && !ctl.zeroBase) |=> satQ);                            // R7
endmodule

// File: rtl/spec_mac.sv
module spec_mac
  import spec_mac_pkg::*;
#(
  parameter int FRAC = 8,
  parameter int NINT = 8,
  parameter int WINT = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inStart,
  input  logic                 inLast,
  input  logic [WINT+FRAC-1:0] opA,
  input  logic [WINT+FRAC-1:0] opB,
  output logic [WINT+FRAC-1:0] accOut,
  output logic                 resValid,
  output logic                 wideMode,
  output logic                 satFlag,
  output logic                 busy
);
  macCtl_t ctl;
  logic    narrowOvf;

  spec_mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inLast(inLast), .narrowOvf(narrowOvf), .ctl(ctl),
    .wideMode(wideMode), .resValid(resValid), .busy(busy)
  );

  spec_mac_dp #(.FRAC(FRAC), .NINT(NINT), .WINT(WINT)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .ctl(ctl),
    .narrowOvf(narrowOvf), .accOut(accOut), .satFlag(satFlag)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rstN |=> (accOut == '0 && !resValid && !wideMode && !satFlag)); // R1
endmodule

// File: tb/spec_mac_bench.sv
module spec_mac_bench;
  localparam int PERIOD = 10;
  localparam longint MAXR = 8388607;
  localparam longint MINR = -8388608;

  logic clk = 1'b0;
  logic rstN, inValid, inStart, inLast;
  logic [23:0] opA, opB, accOut;
  logic resValid, wideMode, satFlag, busy;

  int checks = 0;
  int errors = 0;
  longint refAcc;
  bit refWide, refSat, refRetry, refValid;

  always #(PERIOD/2) clk = ~clk;

  spec_mac u_spec_mac (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inLast(inLast), .opA(opA), .opB(opB), .accOut(accOut),
    .resValid(resValid), .wideMode(wideMode), .satFlag(satFlag), .busy(busy)
  );

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit fits16(input longint v);
    return (v >= -32768) && (v <= 32767);
  endfunction

  // one clock of stimulus with the reference model advanced alongside
  task automatic step(input bit v, input bit s, input bit l, input longint a,
                      input longint b, input string tag, output bit took);
    longint base, tr, sm;
    bit wideE, zb, nov, eb, hit;
    @(negedge clk);
    chk(tag, "accOut", longint'($signed(accOut)), refAcc);
    chk(tag, "wideMode", wideMode, refWide);
    chk(tag, "satFlag", satFlag, refSat);
    chk(tag, "resValid", resValid, refValid);
    inValid = v; inStart = s; inLast = l;
    opA = a[23:0]; opB = b[23:0];
    #1;
    wideE = refRetry || (refWide && !s);
    zb    = s && !refRetry;
    base  = zb ? 0 : refAcc;
    tr    = (a * b) >>> 8;
    sm    = base + tr;
    nov   = !fits16(a) || !fits16(b) || !fits16(tr) || !fits16(sm);
    eb    = v && !wideE && nov;
    chk(tag, "busy", busy, eb);
    took = v && !eb;
    @(posedge clk);
    if (took) begin
      hit = 0;
      if (sm > MAXR) begin sm = MAXR; hit = 1; end
      else if (sm < MINR) begin sm = MINR; hit = 1; end
      refAcc  = sm;
      refSat  = (zb ? 1'b0 : refSat) | hit;
      refWide = wideE;
    end else if (eb) begin
      refWide = 1;
      if (zb) begin refAcc = 0; refSat = 0; end
    end
    refValid = took && l;
    refRetry = eb;
  endtask

  task automatic sendOp(input bit s, input bit l, input longint a, input longint b, input string tag);
    bit took;
    int tries = 0;
    do begin
      step(1, s, l, a, b, tag, took);
      tries++;
    end while (!took && tries < 3);
    if (!took) chk(tag, "retry accepted", 0, 1);     // R10
  endtask

  task automatic idle(input int n, input string tag);
    bit took;
    for (int i = 0; i < n; i++)
      step(0, i[0], ~i[0], longint'(i * 7919 - 30000), longint'(-i * 104729), tag, took);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; inValid = 0; inStart = 0; inLast = 0; opA = '0; opB = '0;
    refAcc = 0; refWide = 0; refSat = 0; refRetry = 0; refValid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk("R1", "accOut", longint'($signed(accOut)), 0);
    chk("R1", "resValid", resValid, 0);
    chk("R1", "wideMode", wideMode, 0);
    chk("R1", "satFlag", satFlag, 0);
    chk("R1", "busy", busy, 0);

    // R2 / R8: short narrow run with fractions, including negative truncation
    sendOp(1, 0, 384, 576, "R2");     // 1.5 * 2.25
    sendOp(0, 0, -1, 1, "R2");        // -1/256 * 1/256 floors to -1/256
    sendOp(0, 0, -300, 77, "R2");
    sendOp(0, 1, 1000, -5, "R8");
    idle(2, "R8");

    // R9: junk while inValid low leaves state alone
    idle(4, "R9");

    // R4 / R5 / R6: many small products crossing the 8-bit integer range
    for (int i = 0; i < 30; i++)
      sendOp(i == 0, i == 29, 768, 512, "R5");      // 3.0 * 2.0 each
    idle(2, "R6");
    sendOp(0, 1, 256, 256, "R6");                    // no start: stays wide

    // R3 / R4: start pair with an oversized operand
    sendOp(1, 0, 51200, 128, "R4");                  // 200.0 * 0.5
    sendOp(0, 1, 256, -256, "R3");
    // R3: start returns to narrow mode
    sendOp(1, 1, 512, 512, "R3");
    idle(1, "R3");

    // R4: product out of narrow range
    sendOp(1, 0, 5120, 2560, "R4");                  // 20.0 * 10.0
    sendOp(0, 1, -256, 256, "R4");

    // R7: positive and negative clamping, sticky flag
    sendOp(1, 0, 51200, 51200, "R7");                // 200 * 200
    sendOp(0, 0, -2560, 256, "R7");
    sendOp(0, 0, -51200, 51200, "R7");
    sendOp(0, 0, -51200, 51200, "R7");
    sendOp(0, 0, -51200, 51200, "R7");
    sendOp(0, 1, 100, 100, "R7");
    idle(1, "R7");
    sendOp(1, 1, 256, 256, "R3");                    // clears the flag
    idle(1, "R3");

    // R2: mixed random runs
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 8; i++) begin
        longint a, b;
        a = longint'($urandom_range(0, 8192)) - 4096;
        b = longint'($urandom_range(0, 4096)) - 2048;
        if (r % 7 == 3 && i == 4) a = a * 64;
        sendOp(i == 0, i == 7, a, b, "R2");
      end
      if (r % 3 == 0) idle(1, "R9");
    end
    idle(2, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule